// File: doc/BRIEF.md
# Sequential Restoring Floating-Point Divider

This block divides one unpacked extended-precision floating value by another. Each operand arrives as three fields: a sign bit, a 15-bit biased exponent (bias 16384) and a 128-bit fraction. The fraction is normalized with its most significant bit set, and its value is taken as 0.f × 2^(exp − bias). A one-cycle `start` pulse latches both operands. The block then runs a restoring compare-and-subtract loop, one quotient bit per clock for 128 clocks. It normalizes the quotient with single-bit left shifts and reports the result with a one-cycle `done` pulse.

A zero divisor exponent is reported through `div_zero` and produces no quotient. A zero dividend exponent returns the dividend fields as the result. Rounding, packing into a storage format, exponent range faults and the remainder are left to the surrounding datapath. For that reason the result exponent is given as a signed value two bits wider than the input exponent, so that it can carry values outside the storable range.

Top module: `fdiv_seq`

## Requirements
- R1: After a synchronous active-low reset, `done` and `div_zero` are 0, and `q_sign`, `q_exp` and `q_frac` are all 0.
- R2: An accepted `start` with `dvs_exp` equal to 0 makes `done` and `div_zero` high in the cycle right after the accepting edge. The quotient outputs keep their previous values. This case wins over a zero dividend exponent.
- R3: An accepted `start` with a nonzero divisor exponent and `dvd_exp` equal to 0 makes `done` high in the cycle right after the accepting edge, with `div_zero` low. `q_sign`, `q_exp` and `q_frac` then equal `dvd_sign`, `dvd_exp` (zero-extended) and `dvd_frac`.
- R4: For a regular divide, `q_sign` is `dvd_sign` XOR `dvs_sign`.
- R5: For a regular divide, `q_exp` (signed) equals `dvd_exp − dvs_exp + 16384 + 1 − k`, where k is the number of normalization shifts (0 or 1 for normalized operands).
- R6: For a regular divide, with A = `dvd_frac` >> 1 and D = `dvs_frac` >> 1, the raw quotient is floor(A·2^127 / D). `q_frac` is that quotient shifted left until bit 127 is 1.
- R7: For a regular divide, `done` rises 129 + k clock edges after the edge that accepted `start`.
- R8: `done` is a single-cycle pulse, and `div_zero` is high only together with `done`.
- R9: A `start` pulse that arrives while a divide is in progress is ignored. The running divide completes with its own latency and result.
- R10: For a regular divide with normalized operands, bit 127 of `q_frac` is 1 when `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts an operation when the block is idle |
| dvd_sign | input | 1 | Dividend sign |
| dvd_exp | input | 15 | Dividend biased exponent |
| dvd_frac | input | 128 | Dividend fraction, bit 127 set |
| dvs_sign | input | 1 | Divisor sign |
| dvs_exp | input | 15 | Divisor biased exponent |
| dvs_frac | input | 128 | Divisor fraction, bit 127 set |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Divisor was zero, valid with `done` |
| q_sign | output | 1 | Quotient sign |
| q_exp | output | 17 | Quotient exponent, signed, biased |
| q_frac | output | 128 | Quotient fraction, normalized |

## Verification
A wrong quotient bit in one loop iteration shows up only when `done` rises, 129 or 130 edges later, as a `q_frac` that differs from the floor-division reference. A remainder that breaks its bound corrupts every later bit. A miscounted loop or a missed normalization step moves `done` by one or more cycles and shifts `q_exp` by the same amount, so checking latency and exponent together pins down control errors at the end of the operation. The zero-operand paths must respond on the very next edge, with the quotient outputs either held unchanged or equal to the dividend.

// File: rtl/fdiv_pkg.sv
// Package: shared types for the sequential restoring divider.
// Assumes nothing beyond a standard SystemVerilog compile order.
package fdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_NORM = 2'd2
    } fdiv_state_e;
endpackage

// File: rtl/fdiv_cmp.sv
// Module: unsigned magnitude compare, a >= b, evaluated word by word.
// The most significant word that differs decides the result.
// Assumes W is a whole multiple of WORD_W.
module fdiv_cmp #(
    parameter int W      = 128,
    parameter int WORD_W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         a_ge_b
);
    localparam int NWORDS = W / WORD_W;

    logic [NWORDS-1:0] word_gt;
    logic [NWORDS-1:0] word_eq;

    // Per-word relation flags
    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        assign word_gt[i] = a[i*WORD_W +: WORD_W] > b[i*WORD_W +: WORD_W];
        assign word_eq[i] = a[i*WORD_W +: WORD_W] == b[i*WORD_W +: WORD_W];
    end

    // Priority resolve: higher words override lower ones; all equal gives 1
    always_comb begin
        a_ge_b = 1'b1;
        for (int i = 0; i < NWORDS; i++) begin
            if (!word_eq[i]) a_ge_b = word_gt[i];
        end
    end
endmodule

// File: rtl/fdiv_step.sv
// Module: one restoring division iteration.
// Compares the partial remainder with the divisor, subtracts when the
// remainder is not smaller, then doubles the remainder.
// Assumes rem < 2*dvs on entry, so the doubled value fits in W bits.
module fdiv_step #(
    parameter int W      = 128,
    parameter int WORD_W = 32
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] dvs,
    output logic         q_bit,
    output logic [W-1:0] rem_next
);
    logic [W-1:0] rem_sel;

    fdiv_cmp #(.W(W), .WORD_W(WORD_W)) i_cmp (
        .a      (rem),
        .b      (dvs),
        .a_ge_b (q_bit)
    );

    // Restore-or-subtract, then shift left one
    always_comb begin
        rem_sel  = q_bit ? (rem - dvs) : rem;
        rem_next = {rem_sel[W-2:0], 1'b0};
    end
endmodule

// File: rtl/fdiv_seq.sv
// Module: sequential restoring floating divider, top level.
// Divides an unpacked dividend by an unpacked divisor: one quotient bit
// per clock for FRAC_W clocks, then one left shift per clock until the
// quotient MSB is set. Assumes nonzero-exponent operands carry normalized
// fractions (MSB set). start is ignored while an operation is running.
module fdiv_seq
    import fdiv_pkg::*;
#(
    parameter int FRAC_W = 128,
    parameter int EXP_W  = 15,
    parameter int BIAS   = 16384,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     dvd_sign,
    input  logic [EXP_W-1:0]         dvd_exp,
    input  logic [FRAC_W-1:0]        dvd_frac,
    input  logic                     dvs_sign,
    input  logic [EXP_W-1:0]         dvs_exp,
    input  logic [FRAC_W-1:0]        dvs_frac,
    output logic                     done,
    output logic                     div_zero,
    output logic                     q_sign,
    output logic signed [EXP_W+1:0]  q_exp,
    output logic [FRAC_W-1:0]        q_frac
);
    localparam int QEXP_W = EXP_W + 2;
    localparam int CNT_W  = $clog2(FRAC_W);
    localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(FRAC_W - 1);
    localparam int MSB    = FRAC_W - 1;

    fdiv_state_e              state_q;
    logic [CNT_W-1:0]         cnt_q;
    logic [FRAC_W-1:0]        rem_q;
    logic [FRAC_W-1:0]        dvs_q;
    logic [FRAC_W-1:0]        quo_q;
    logic                     sgn_q;
    logic signed [QEXP_W-1:0] exp_q;
    logic                     done_q;
    logic                     dz_q;
    logic                     qs_q;
    logic signed [QEXP_W-1:0] qe_q;
    logic [FRAC_W-1:0]        qf_q;

    logic                     step_bit;
    logic [FRAC_W-1:0]        step_rem;
    logic signed [QEXP_W-1:0] exp_init;

    // Initial exponent: difference plus bias plus one for the pre-shift
    assign exp_init = $signed({2'b00, dvd_exp}) - $signed({2'b00, dvs_exp})
                    + QEXP_W'(BIAS + 1);

    fdiv_step #(.W(FRAC_W), .WORD_W(WORD_W)) i_step (
        .rem      (rem_q),
        .dvs      (dvs_q),
        .q_bit    (step_bit),
        .rem_next (step_rem)
    );

    // Control and datapath registers: accept, iterate, normalize, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
            quo_q   <= '0;
            sgn_q   <= 1'b0;
            exp_q   <= '0;
            done_q  <= 1'b0;
            dz_q    <= 1'b0;
            qs_q    <= 1'b0;
            qe_q    <= '0;
            qf_q    <= '0;
        end else begin
            done_q <= 1'b0;
            dz_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (dvs_exp == '0) begin
                            done_q <= 1'b1;
                            dz_q   <= 1'b1;
                        end else if (dvd_exp == '0) begin
                            done_q <= 1'b1;
                            qs_q   <= dvd_sign;
                            qe_q   <= {2'b00, dvd_exp};
                            qf_q   <= dvd_frac;
                        end else begin
                            state_q <= ST_DIV;
                            cnt_q   <= '0;
                            rem_q   <= dvd_frac >> 1;
                            dvs_q   <= dvs_frac >> 1;
                            quo_q   <= '0;
                            sgn_q   <= dvd_sign ^ dvs_sign;
                            exp_q   <= exp_init;
                        end
                    end
                end
                ST_DIV: begin
                    quo_q <= {quo_q[FRAC_W-2:0], step_bit};
                    rem_q <= step_rem;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_IT) state_q <= ST_NORM;
                end
                ST_NORM: begin
                    if (quo_q[MSB] || quo_q == '0) begin
                        done_q  <= 1'b1;
                        qs_q    <= sgn_q;
                        qe_q    <= exp_q;
                        qf_q    <= quo_q;
                        state_q <= ST_IDLE;
                    end else begin
                        quo_q <= quo_q << 1;
                        exp_q <= exp_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign div_zero = dz_q;
    assign q_sign   = qs_q;
    assign q_exp    = qe_q;
    assign q_frac   = qf_q;

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: divide-by-zero flag never appears without done
    a_r8_dz_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> done);

    // R2: zero divisor answers next cycle and leaves the quotient untouched
    a_r2_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && dvs_exp == '0)
            |=> (done && div_zero && $stable(q_frac) && $stable(q_exp)));

    // R6: partial remainder stays below twice the divisor during the loop
    a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV) |-> ({1'b0, rem_q} < {dvs_q, 1'b0}));

    // R5: every normalization shift lowers the exponent by exactly one
    a_r5_norm_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && !quo_q[MSB] && quo_q != '0)
            |=> (exp_q == $past(exp_q) - 1'b1));

    // R10: a normalized quotient is reported with its MSB set
    a_r10_norm_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORM && quo_q[MSB]) |=> (done && q_frac[MSB]));

    // R9: no completion is reported while the loop is still running
    a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV) |=> !div_zero);
endmodule

// File: tb/test_fdiv_seq.sv
// Bench for fdiv_seq: a table of regular divides walked by one loop,
// then directed tests for reset, zero operands and busy start.
module test_fdiv_seq;
    localparam int FW = 128;
    localparam int EW = 15;

    typedef struct packed {
        logic          sa;
        logic [EW-1:0] ea;
        logic [FW-1:0] fa;
        logic          sb;
        logic [EW-1:0] eb;
        logic [FW-1:0] fb;
        logic [1:0]    k;     // expected normalization shifts
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 15'd16384, 128'h8000_0000_0000_0000_0000_0000_0000_0000,
          1'b0, 15'd16384, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 2'd0},
        '{1'b0, 15'd16390, 128'h8000_0000_0000_0000_0000_0000_0000_0000,
          1'b1, 15'd16380, 128'hC000_0000_0000_0000_0000_0000_0000_0000, 2'd1},
        '{1'b1, 15'd32767, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
          1'b0, 15'd1,     128'h8000_0000_0000_0000_0000_0000_0000_0000, 2'd0},
        '{1'b1, 15'd16000, 128'hC000_0000_0000_0000_0000_0000_0000_0000,
          1'b1, 15'd17000, 128'hA000_0000_0000_0000_0000_0000_0000_0000, 2'd0},
        '{1'b0, 15'd1,     128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834,
          1'b0, 15'd32767, 128'hB504_F333_F9DE_6484_597D_89B3_754A_BE9F, 2'd1},
        '{1'b1, 15'd20000, 128'h8000_0000_0000_0000_0000_0000_0000_0001,
          1'b0, 15'd12000, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 2'd1},
        '{1'b0, 15'd5,     128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
          1'b1, 15'd7,     128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFE, 2'd0}
    };

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic                   dvd_sign = 1'b0;
    logic [EW-1:0]          dvd_exp = '0;
    logic [FW-1:0]          dvd_frac = '0;
    logic                   dvs_sign = 1'b0;
    logic [EW-1:0]          dvs_exp = '0;
    logic [FW-1:0]          dvs_frac = '0;
    logic                   done;
    logic                   div_zero;
    logic                   q_sign;
    logic signed [EW+1:0]   q_exp;
    logic [FW-1:0]          q_frac;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    fdiv_seq i_fdiv_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .dvd_sign (dvd_sign),
        .dvd_exp  (dvd_exp),
        .dvd_frac (dvd_frac),
        .dvs_sign (dvs_sign),
        .dvs_exp  (dvs_exp),
        .dvs_frac (dvs_frac),
        .done     (done),
        .div_zero (div_zero),
        .q_sign   (q_sign),
        .q_exp    (q_exp),
        .q_frac   (q_frac)
    );

    task automatic chk_v(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_i(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference quotient fraction: floor(A*2^127/D), then normalized
    function automatic logic [FW-1:0] ref_frac(input logic [FW-1:0] fa, input logic [FW-1:0] fb);
        logic [255:0] num;
        logic [255:0] den;
        logic [255:0] quo;
        logic [FW-1:0] q;
        num = {1'b0, (fa >> 1), 127'b0};
        den = {128'b0, (fb >> 1)};
        quo = num / den;
        q = quo[FW-1:0];
        while (q != '0 && !q[FW-1]) q = q << 1;
        return q;
    endfunction

    // Issue one operation and wait for done; optional extra start mid-run
    task automatic run_op(input logic sa, input logic [EW-1:0] ea, input logic [FW-1:0] fa,
                          input logic sb, input logic [EW-1:0] eb, input logic [FW-1:0] fb,
                          input bit inject, output int lat);
        @(negedge clk);
        dvd_sign = sa; dvd_exp = ea; dvd_frac = fa;
        dvs_sign = sb; dvs_exp = eb; dvs_frac = fb;
        start = 1'b1;
        lat = 0;
        while (1) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = 1'b0;
            if (inject && lat == 50) begin
                start = 1'b1;
                dvs_exp = '0;
                dvd_frac = ~fa;
            end
            if (done || lat > 400) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lat;
        logic [FW-1:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_v("R1 done", 128'(done), 128'(0));
        chk_v("R1 div_zero", 128'(div_zero), 128'(0));
        chk_v("R1 q_frac", q_frac, '0);
        chk_i("R1 q_exp", int'(q_exp), 0);

        // Table walk: R4 R5 R6 R7 R8 R10
        for (int v = 0; v < NVEC; v++) begin
            run_op(VECS[v].sa, VECS[v].ea, VECS[v].fa, VECS[v].sb, VECS[v].eb, VECS[v].fb, 1'b0, lat);
            chk_i($sformatf("R7 latency vec%0d", v), lat, 130 + int'(VECS[v].k));
            chk_v($sformatf("R4 sign vec%0d", v), 128'(q_sign), 128'(VECS[v].sa ^ VECS[v].sb));
            chk_i($sformatf("R5 exp vec%0d", v), int'(q_exp),
                  int'(VECS[v].ea) - int'(VECS[v].eb) + 16385 - int'(VECS[v].k));
            chk_v($sformatf("R6 frac vec%0d", v), q_frac, ref_frac(VECS[v].fa, VECS[v].fb));
            chk_v($sformatf("R10 msb vec%0d", v), 128'(q_frac[FW-1]), 128'(1));
            chk_v($sformatf("R8 no dz vec%0d", v), 128'(div_zero), 128'(0));
            @(negedge clk);
            chk_v($sformatf("R8 pulse vec%0d", v), 128'(done), 128'(0));
        end

        // R2: zero divisor, quotient outputs held from the previous divide
        held = q_frac;
        run_op(1'b1, 15'd100, 128'hC000_0000_0000_0000_0000_0000_0000_0000,
               1'b0, 15'd0, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 1'b0, lat);
        chk_i("R2 latency", lat, 1);
        chk_v("R2 div_zero", 128'(div_zero), 128'(1));
        chk_v("R2 q_frac held", q_frac, held);
        @(negedge clk);
        chk_v("R8 dz pulse", 128'(div_zero), 128'(0));

        // R2: both exponents zero, divisor case wins
        run_op(1'b0, 15'd0, '0, 1'b0, 15'd0, '0, 1'b0, lat);
        chk_v("R2 precedence div_zero", 128'(div_zero), 128'(1));
        chk_v("R2 precedence q_frac held", q_frac, held);

        // R3: zero dividend exponent returns the dividend fields
        run_op(1'b0, 15'd0, 128'h0, 1'b1, 15'd300,
               128'h8000_0000_0000_0000_0000_0000_0000_0000, 1'b0, lat);
        chk_i("R3 latency", lat, 1);
        chk_v("R3 div_zero", 128'(div_zero), 128'(0));
        chk_v("R3 q_frac", q_frac, '0);
        chk_i("R3 q_exp", int'(q_exp), 0);
        chk_v("R3 q_sign", 128'(q_sign), 128'(0));

        // R9: a second start during the loop has no effect
        run_op(VECS[1].sa, VECS[1].ea, VECS[1].fa, VECS[1].sb, VECS[1].eb, VECS[1].fb, 1'b1, lat);
        chk_i("R9 latency", lat, 131);
        chk_v("R9 div_zero", 128'(div_zero), 128'(0));
        chk_v("R9 frac", q_frac, ref_frac(VECS[1].fa, VECS[1].fb));
        chk_i("R9 exp", int'(q_exp), 16390 - 16380 + 16385 - 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule